// File: doc/BRIEF.md
# Reset and Halt Controller

This block decides, cycle by cycle, whether a small 4-bit microcontroller core is held in reset, running or frozen in halt. It merges four requests. The first is a synchronous active-low power-on reset. The second is an active-high external reset pin. The third is an active-low external halt pin. The last is a software halt request, which has its own wake pulse. From these it produces a reset strobe, the values the core loads while that strobe is high, and a run enable that freezes every register of the core, including its RAM, while halted.

The block also sits between the core and its pads. In reset the output latches are forced to all ones. In halt, a static option selects one of two behaviours. In the first, the pads keep the value they had just before the halt. In the second, they float with their pull-ups off. The segment and common lines of the display are driven to one shared level while halted, which blanks the glass. Reset always wins over any halt source and also cancels a pending software halt.

Top module: `rst_halt_ctrl`

## Requirements
- R1: With `por_n` low at a clock edge, `core_rst` is 1 after that edge. A change on `rst_pin` appears on `core_rst` after the third rising edge that samples it, on both assertion and release.
- R2: `rst_pc` is 11'h7FF, with the page number 31 in bits [10:6] and the address 0x3F in bits [5:0]. `rst_flags` is 7'h70: bits [3:0] (two request flags, interrupt enable, carry) are 0 and bits [6:4] (two interrupt flags, timer flag) are 1.
- R3: While `core_rst` is 1, `pad_out` is all ones, and `pad_oe` and `pad_pu` are all ones.
- R4: When `halt_pin_n` goes low (or high), `core_run_en` goes to 0 (or 1) and `disp_blank` goes to 1 (or 0) after the third rising edge, and the core resumes with no reset.
- R5: In hold mode (`opt_halt_tristate` = 0), `pad_out` keeps the value that `core_io_out` had at the last edge before the halt. Changes on `core_io_out` during the halt have no effect, and `pad_oe` stays all ones.
- R6: In float mode (`opt_halt_tristate` = 1), `pad_oe` and `pad_pu` are all zeros while halted and all ones when running.
- R7: While halted, every bit of `seg_out` and `com_out` is 0. Otherwise they equal `core_seg` and `core_com`.
- R8: A one-cycle `sw_halt_req` with `opt_sw_halt_en` = 1 halts the core after the second rising edge. With `opt_sw_halt_en` = 0 the request is ignored.
- R9: A one-cycle `sw_wake` ends a software halt, and `core_run_en` returns to 1 after the second rising edge.
- R10: Reset overrides every halt source: `core_rst` and `disp_blank` are never both 1. A software halt pending when reset arrives is cleared, so the core runs once reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_pin | input | 1 | External reset, active high, asynchronous to clk |
| halt_pin_n | input | 1 | External halt, active low, asynchronous to clk |
| sw_halt_req | input | 1 | Software halt request pulse |
| sw_wake | input | 1 | Wake pulse ending a software halt |
| opt_sw_halt_en | input | 1 | Static option: software halt allowed |
| opt_halt_tristate | input | 1 | Static option: 1 floats pads in halt, 0 holds them |
| core_io_out | input | 8 | Output latch values from the core |
| core_seg | input | 32 | Segment drive from the core |
| core_com | input | 4 | Common drive from the core |
| core_rst | output | 1 | Reset strobe to the core |
| core_run_en | output | 1 | Clock enable for all core state |
| rst_pc | output | 11 | Program counter load value {page, address} |
| rst_flags | output | 7 | Flag load values |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| seg_out | output | 32 | Segment lines to the display |
| com_out | output | 4 | Common lines to the display |
| disp_blank | output | 1 | High while the display is blanked |

## Verification
A wrong control state shows at the ports on the very next sample. It appears as a run enable, reset strobe or blank flag that disagrees with the pin history, offset by the fixed synchronizer latency. A lost or stuck software-halt latch shows two edges after the request or wake that should have changed it. A hold register that keeps tracking during a halt shows as soon as the core data changes inside the halt window. Random pin and request traffic is checked on every cycle against a latency model in the bench. Directed cases pin down the exact edge counts, the ignored request and reset overriding halt.

// File: rtl/rhc_pkg.sv
// Package: shared types for the reset and halt controller.
// Assumes: flag order in core_flags_t is the order the core decodes.
package rhc_pkg;

    // Control state of the core as seen by this block.
    typedef enum logic [1:0] {
        CTL_RESET = 2'd0,
        CTL_RUN   = 2'd1,
        CTL_HALT  = 2'd2
    } ctl_state_t;

    // Core flags loaded during reset; bit 0 is irq_a, bit 6 is timer_f.
    typedef struct packed {
        logic timer_f;
        logic ifl1;
        logic ifl0;
        logic carry;
        logic int_en;
        logic irq_b;
        logic irq_a;
    } core_flags_t;

    localparam core_flags_t FLAGS_AT_RESET = '{
        timer_f: 1'b1, ifl1: 1'b1, ifl0: 1'b1,
        carry: 1'b0, int_en: 1'b0, irq_b: 1'b0, irq_a: 1'b0
    };

endpackage

// File: rtl/rhc_sync.sv
// Module: multi-flop synchronizer for one asynchronous pin.
// Assumes: STAGES >= 2; por_n is synchronous to clk and loads RST_VAL.
module rhc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!por_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rhc_seq.sv
// Module: reset/run/halt sequencer with the software halt latch.
// Assumes: rst_req and ext_halt are already synchronized; reset outranks halt.
module rhc_seq
    import rhc_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_req,
    input  logic       ext_halt,
    input  logic       sw_halt_req,
    input  logic       sw_wake,
    input  logic       sw_halt_en,
    output ctl_state_t state,
    output logic       sw_pending
);

    ctl_state_t state_nx;

    // Software halt latch: reset clears it, wake clears it, an enabled request sets it.
    always_ff @(posedge clk) begin
        if (!por_n || rst_req)              sw_pending <= 1'b0;
        else if (sw_wake)                   sw_pending <= 1'b0;
        else if (sw_halt_req && sw_halt_en) sw_pending <= 1'b1;
    end

    // Next state: reset first, then either halt source, else run.
    always_comb begin
        if (rst_req)                      state_nx = CTL_RESET;
        else if (ext_halt || sw_pending)  state_nx = CTL_HALT;
        else                              state_nx = CTL_RUN;
    end

    // State register; power-on reset enters reset state.
    always_ff @(posedge clk) begin
        if (!por_n) state <= CTL_RESET;
        else        state <= state_nx;
    end

    assert_sw_ignored_R8: assert property (@(posedge clk) disable iff (!por_n)
        (!sw_halt_en && !sw_pending) |=> !sw_pending);

    assert_wake_clears_R9: assert property (@(posedge clk) disable iff (!por_n)
        sw_wake |=> !sw_pending);

    assert_rst_clears_sw_R10: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> (!sw_pending && state == CTL_RESET));

    assert_ext_halt_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_req && ext_halt) |=> state == CTL_HALT);

endmodule

// File: rtl/rhc_io_gate.sv
// Module: pad gating for the discrete output latches.
// Assumes: in_reset and halted are never both high; tristate_opt is static.
module rhc_io_gate #(
    parameter int IO_W = 8
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            in_reset,
    input  logic            halted,
    input  logic            tristate_opt,
    input  logic [IO_W-1:0] core_io_out,
    output logic [IO_W-1:0] pad_out,
    output logic [IO_W-1:0] pad_oe,
    output logic [IO_W-1:0] pad_pu
);

    logic [IO_W-1:0] hold_q;
    logic            float_pads;

    assign float_pads = halted && tristate_opt;

    for (genvar i = 0; i < IO_W; i++) begin : g_pad
        // Hold register: preset in reset, tracks the core while running, frozen in halt.
        always_ff @(posedge clk) begin
            if (!por_n || in_reset) hold_q[i] <= 1'b1;
            else if (!halted)       hold_q[i] <= core_io_out[i];
        end

        // Pad drive selection per bit.
        always_comb begin
            if (in_reset)    pad_out[i] = 1'b1;
            else if (halted) pad_out[i] = hold_q[i];
            else             pad_out[i] = core_io_out[i];
            pad_oe[i] = !float_pads;
            pad_pu[i] = !float_pads;
        end
    end

    assert_preset_R3: assert property (@(posedge clk) disable iff (!por_n)
        in_reset |=> (&hold_q));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        (halted && $past(halted) && !tristate_opt) |-> (pad_out == $past(pad_out)));

endmodule

// File: rtl/rhc_disp_gate.sv
// Module: blanks the display by driving segment and common lines to one level.
// Assumes: purely combinational; blank is registered upstream.
module rhc_disp_gate #(
    parameter int   SEG_W     = 32,
    parameter int   COM_W     = 4,
    parameter logic BLANK_LVL = 1'b0
) (
    input  logic             blank,
    input  logic [SEG_W-1:0] core_seg,
    input  logic [COM_W-1:0] core_com,
    output logic [SEG_W-1:0] seg_out,
    output logic [COM_W-1:0] com_out
);

    // Select the shared level or pass the core drive.
    always_comb begin
        seg_out = blank ? {SEG_W{BLANK_LVL}} : core_seg;
        com_out = blank ? {COM_W{BLANK_LVL}} : core_com;
    end

endmodule

// File: rtl/rst_halt_ctrl.sv
// Module: top of the reset and halt controller.
// Assumes: por_n is synchronous to clk; rst_pin and halt_pin_n are asynchronous.
module rst_halt_ctrl
    import rhc_pkg::*;
#(
    parameter int   IO_W        = 8,
    parameter int   SEG_W       = 32,
    parameter int   COM_W       = 4,
    parameter int   SYNC_STAGES = 2,
    parameter int   PAGE_W      = 5,
    parameter int   ADDR_W      = 6,
    parameter int   RST_PAGE    = 31,
    parameter int   RST_ADDR    = 63,
    parameter logic BLANK_LVL   = 1'b0,
    localparam int  PC_W        = PAGE_W + ADDR_W,
    localparam int  FLAG_W      = $bits(core_flags_t)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              halt_pin_n,
    input  logic              sw_halt_req,
    input  logic              sw_wake,
    input  logic              opt_sw_halt_en,
    input  logic              opt_halt_tristate,
    input  logic [IO_W-1:0]   core_io_out,
    input  logic [SEG_W-1:0]  core_seg,
    input  logic [COM_W-1:0]  core_com,
    output logic              core_rst,
    output logic              core_run_en,
    output logic [PC_W-1:0]   rst_pc,
    output logic [FLAG_W-1:0] rst_flags,
    output logic [IO_W-1:0]   pad_out,
    output logic [IO_W-1:0]   pad_oe,
    output logic [IO_W-1:0]   pad_pu,
    output logic [SEG_W-1:0]  seg_out,
    output logic [COM_W-1:0]  com_out,
    output logic              disp_blank
);

    logic       rst_req;
    logic       ext_halt;
    logic       sw_pending;
    ctl_state_t state;

    rhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rst_sync (
        .clk(clk), .por_n(por_n), .d(rst_pin), .q(rst_req)
    );

    rhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_halt_sync (
        .clk(clk), .por_n(por_n), .d(!halt_pin_n), .q(ext_halt)
    );

    rhc_seq i_seq (
        .clk(clk), .por_n(por_n), .rst_req(rst_req), .ext_halt(ext_halt),
        .sw_halt_req(sw_halt_req), .sw_wake(sw_wake), .sw_halt_en(opt_sw_halt_en),
        .state(state), .sw_pending(sw_pending)
    );

    // Decode the control state into core-facing strobes.
    always_comb begin
        core_rst    = (state == CTL_RESET);
        core_run_en = (state == CTL_RUN);
        disp_blank  = (state == CTL_HALT);
    end

    assign rst_pc    = {PAGE_W'(RST_PAGE), ADDR_W'(RST_ADDR)};
    assign rst_flags = FLAGS_AT_RESET;

    rhc_io_gate #(.IO_W(IO_W)) i_io_gate (
        .clk(clk), .por_n(por_n), .in_reset(core_rst), .halted(disp_blank),
        .tristate_opt(opt_halt_tristate), .core_io_out(core_io_out),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    rhc_disp_gate #(.SEG_W(SEG_W), .COM_W(COM_W), .BLANK_LVL(BLANK_LVL)) i_disp_gate (
        .blank(disp_blank), .core_seg(core_seg), .core_com(core_com),
        .seg_out(seg_out), .com_out(com_out)
    );

    assert_blank_R7: assert property (@(posedge clk) disable iff (!por_n)
        disp_blank |-> (seg_out == {SEG_W{BLANK_LVL}} && com_out == {COM_W{BLANK_LVL}}));

    assert_run_excl_R10: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({core_rst, core_run_en, disp_blank}) && !(sw_pending && core_rst));

endmodule

// File: tb/test_rst_halt_ctrl.sv
module test_rst_halt_ctrl;

    logic        clk = 1'b0;
    logic        por_n, rst_pin, halt_pin_n, sw_halt_req, sw_wake;
    logic        opt_sw_halt_en, opt_halt_tristate;
    logic [7:0]  core_io_out;
    logic [31:0] core_seg;
    logic [3:0]  core_com;
    logic        core_rst, core_run_en, disp_blank;
    logic [10:0] rst_pc;
    logic [6:0]  rst_flags;
    logic [7:0]  pad_out, pad_oe, pad_pu;
    logic [31:0] seg_out;
    logic [3:0]  com_out;

    int checks = 0;
    int errors = 0;

    // Latency model state, from the requirement edge counts.
    logic       m_r1, m_r2, m_h1, m_h2, m_rst, m_halt, m_sw;
    logic [7:0] m_hold;

    always #2.5 clk = ~clk;

    rst_halt_ctrl i_rst_halt_ctrl (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .halt_pin_n(halt_pin_n),
        .sw_halt_req(sw_halt_req), .sw_wake(sw_wake), .opt_sw_halt_en(opt_sw_halt_en),
        .opt_halt_tristate(opt_halt_tristate), .core_io_out(core_io_out),
        .core_seg(core_seg), .core_com(core_com), .core_rst(core_rst),
        .core_run_en(core_run_en), .rst_pc(rst_pc), .rst_flags(rst_flags),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .seg_out(seg_out), .com_out(com_out), .disp_blank(disp_blank)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_pad(input logic rst, input logic halt,
                                           input logic [7:0] hold, input logic [7:0] io);
        if (rst) return 8'hFF;
        if (halt) return hold;
        return io;
    endfunction

    // One clock: advance the model with the driven inputs, then compare at the falling edge.
    task automatic tick();
        logic n_sw, n_halt;
        logic [7:0] n_hold;
        @(posedge clk);
        if (!por_n) begin
            m_r1 = 1; m_r2 = 1; m_h1 = 0; m_h2 = 0;
            m_rst = 1; m_halt = 0; m_sw = 0; m_hold = 8'hFF;
        end else begin
            n_sw   = m_r2 ? 1'b0 : sw_wake ? 1'b0 : (sw_halt_req && opt_sw_halt_en) ? 1'b1 : m_sw;
            n_halt = !m_r2 && (m_h2 || m_sw);
            n_hold = m_rst ? 8'hFF : (!m_halt ? core_io_out : m_hold);
            m_rst = m_r2; m_r2 = m_r1; m_r1 = rst_pin;
            m_h2 = m_h1; m_h1 = !halt_pin_n;
            m_halt = n_halt; m_sw = n_sw; m_hold = n_hold;
        end
        @(negedge clk);
        check("R1 R10 core_rst", core_rst, m_rst);
        check("R4 R8 R9 core_run_en", core_run_en, !m_rst && !m_halt);
        check("R4 R10 disp_blank", disp_blank, m_halt);
        check("R3 R5 pad_out", pad_out, exp_pad(m_rst, m_halt, m_hold, core_io_out));
        check("R6 pad_oe", pad_oe, (m_halt && opt_halt_tristate) ? 8'h00 : 8'hFF);
        check("R6 pad_pu", pad_pu, (m_halt && opt_halt_tristate) ? 8'h00 : 8'hFF);
        check("R7 seg_out", seg_out, m_halt ? 32'h0 : core_seg);
        check("R7 com_out", com_out, m_halt ? 4'h0 : core_com);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        por_n = 0; rst_pin = 1; halt_pin_n = 1; sw_halt_req = 0; sw_wake = 0;
        opt_sw_halt_en = 1; opt_halt_tristate = 0;
        core_io_out = 8'h5A; core_seg = 32'hDEADBEEF; core_com = 4'hA;
        @(negedge clk);
        ticks(2);
        // Reset state and load values
        check("R1 por reset", core_rst, 1'b1);
        check("R2 rst_pc", rst_pc, 11'h7FF);
        check("R2 rst_pc page", rst_pc[10:6], 5'd31);
        check("R2 rst_flags", rst_flags, 7'h70);
        check("R3 pad preset", pad_out, 8'hFF);

        // Pin release latency
        por_n = 1; ticks(2);
        rst_pin = 0; ticks(2);
        check("R1 still in reset after 2 edges", core_rst, 1'b1);
        tick();
        check("R1 released after 3 edges", core_rst, 1'b0);
        check("R3 pads follow core", pad_out, 8'h5A);

        // External halt, hold mode
        halt_pin_n = 0; ticks(2);
        check("R4 running after 2 edges", core_run_en, 1'b1);
        tick();
        check("R4 halted after 3 edges", core_run_en, 1'b0);
        core_io_out = 8'hC3; core_seg = 32'h1234_5678; ticks(2);
        check("R5 pad held", pad_out, 8'h5A);
        check("R5 oe kept", pad_oe, 8'hFF);
        check("R7 seg blank", seg_out, 32'h0);
        halt_pin_n = 1; ticks(3);
        check("R4 resumed", core_run_en, 1'b1);
        check("R5 pad follows again", pad_out, 8'hC3);

        // Float mode
        opt_halt_tristate = 1; halt_pin_n = 0; ticks(3);
        check("R6 oe off", pad_oe, 8'h00);
        check("R6 pu off", pad_pu, 8'h00);
        halt_pin_n = 1; ticks(3);
        check("R6 oe back", pad_oe, 8'hFF);
        opt_halt_tristate = 0;

        // Software halt disabled, then enabled, then wake
        opt_sw_halt_en = 0; sw_halt_req = 1; tick(); sw_halt_req = 0; ticks(3);
        check("R8 request ignored", core_run_en, 1'b1);
        opt_sw_halt_en = 1; sw_halt_req = 1; tick(); sw_halt_req = 0;
        check("R8 not yet halted", core_run_en, 1'b1);
        tick();
        check("R8 halted after 2 edges", disp_blank, 1'b1);
        ticks(3);
        sw_wake = 1; tick(); sw_wake = 0;
        check("R9 still halted after 1 edge", core_run_en, 1'b0);
        tick();
        check("R9 resumed after 2 edges", core_run_en, 1'b1);

        // Reset over halt
        sw_halt_req = 1; tick(); sw_halt_req = 0; ticks(2);
        rst_pin = 1; halt_pin_n = 0; ticks(3);
        check("R10 reset beats halt", {core_rst, disp_blank}, 2'b10);
        halt_pin_n = 1; ticks(2);
        rst_pin = 0; ticks(4);
        check("R10 sw halt cleared by reset", core_run_en, 1'b1);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            rst_pin     = ($urandom % 40) == 0;
            if (($urandom % 12) == 0) halt_pin_n = ~halt_pin_n;
            sw_halt_req = ($urandom % 9) == 0;
            sw_wake     = ($urandom % 11) == 0;
            if (($urandom % 60) == 0) opt_halt_tristate = ~opt_halt_tristate;
            if (($urandom % 60) == 0) opt_sw_halt_en = ~opt_sw_halt_en;
            if (($urandom % 500) == 0) por_n = 0; else por_n = 1;
            core_io_out = 8'($urandom);
            core_seg    = $urandom;
            core_com    = 4'($urandom);
            tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule